// File: doc/BRIEF.md
# System Glue Bus Supervisor

This block sits beside a 68000-style processor and watches every bus cycle. From the word address, the read/write line, the two byte strobes and the supervisor state, it picks which memory or device the access goes to. It drives one select each for ROM, RAM and the peripheral page. The first eight bytes of the address space are served from the start of ROM, so the processor can fetch its reset vectors before any RAM holds data.

The same logic guards the bus. It raises bus error on a write to ROM, on a user-mode access to the protected system area of low RAM, and on an access to the second RAM bank when only one bank is fitted. It also raises bus error when no data acknowledge arrives within a parameterised number of clocks. Once raised, bus error stays high until the address strobe is released.

Three interrupt requests are folded into a registered two-bit priority level. The block also holds a one-bit video refresh-rate register, which the processor reads and writes through the peripheral page and which acknowledges its own cycles.

Top module: `glue_bus_sup`

## Requirements
- R1: A read at byte address 0x000000–0x000007 asserts rom_sel_o and not ram_sel_o, and rom_off_o carries the ROM word offset addr_i[17:1] (0–3).
- R2: A read in 0xFC0000–0xFEFFFF asserts rom_sel_o with rom_off_o = addr_i[17:1]. A write to that range or to 0x000000–0x000007 asserts no select and sets berr_o on the next rising edge.
- R3: An access to 0x000008–0x0007FF with super_i low sets berr_o on the next edge and asserts no select. With super_i high, or at 0x000800 and above, ram_sel_o is asserted.
- R4: An access to 0x200000–0x3FFFFF asserts ram_sel_o when two_banks_i is 1. When two_banks_i is 0 it asserts no select and sets berr_o on the next edge. The range 0x000008–0x1FFFFF does not depend on two_banks_i.
- R5: An access in 0xFF8000–0xFFFFFF asserts per_sel_o. At most one select is high at any time, and each select needs as_i and at least one byte strobe.
- R6: If dtack_o stays low for TIMEOUT consecutive rising edges with as_i high, berr_o rises after the TIMEOUT-th edge. If dtack_o is high at that edge, no bus error is raised. Addresses outside every region always time out.
- R7: berr_o stays high while as_i stays high, and goes low on the first rising edge at which as_i is low.
- R8: One edge after the requests are sampled, ipl_o is 3 if irq_hsync_i is high, else 2 if irq_vsync_i is high, else 1 if irq_mfp_i is high, else 0.
- R9: The rate register sits in the upper byte lane at byte address 0xFF820A. Bit 1 of data_i is 1 for 50 Hz and 0 for 60 Hz. A write with uds_i high updates hz50_o on the next edge, and a write with uds_i low leaves it unchanged. A read returns the bit in rdata_o[1], and any access there drives dtack_o high.
- R10: After reset, berr_o is 0, ipl_o is 0 and hz50_o is 0 (60 Hz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 23 | Word address, bits 23:1 |
| as_i | input | 1 | Address strobe, active high |
| rw_i | input | 1 | 1 read, 0 write |
| uds_i | input | 1 | Upper (even) byte strobe |
| lds_i | input | 1 | Lower (odd) byte strobe |
| super_i | input | 1 | Processor in supervisor state |
| dtack_i | input | 1 | Acknowledge from memory and devices |
| two_banks_i | input | 1 | Second RAM bank fitted |
| irq_mfp_i | input | 1 | Peripheral controller interrupt request |
| irq_vsync_i | input | 1 | Vertical sync interrupt request |
| irq_hsync_i | input | 1 | Horizontal sync interrupt request |
| data_i | input | 8 | Upper-lane write data |
| rom_sel_o | output | 1 | ROM select |
| ram_sel_o | output | 1 | RAM select |
| per_sel_o | output | 1 | Peripheral page select |
| rom_off_o | output | 17 | ROM word offset |
| dtack_o | output | 1 | Acknowledge to processor |
| berr_o | output | 1 | Bus error |
| ipl_o | output | 2 | Encoded interrupt level |
| hz50_o | output | 1 | 1 for 50 Hz, 0 for 60 Hz |
| rdata_o | output | 8 | Upper-lane read data from the rate register |

## Verification
A bus error can have two causes that meet at the same edge: the data acknowledge and the expiry of the timeout. The bench holds the strobe on an unmapped address for one edge fewer than the limit, then raises dtack_i just before the deciding edge, and expects berr_o to stay low. A second run leaves the acknowledge low so that berr_o rises at exactly that edge. A protection fault also meets a missing acknowledge. There the bench expects the bus error one edge after the strobe, long before the counter could expire, and expects it to hold until the strobe falls.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam logic [23:0] OVL_END   = 24'h000008;
  localparam logic [23:0] SYS_END   = 24'h000800;
  localparam logic [23:0] LOW_END   = 24'h200000;
  localparam logic [23:0] HIGH_END  = 24'h400000;
  localparam logic [23:0] ROM_BASE  = 24'hFC0000;
  localparam logic [23:0] ROM_END   = 24'hFF0000;
  localparam logic [23:0] PER_BASE  = 24'hFF8000;
  localparam logic [23:0] RATE_ADDR = 24'hFF820A;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_ROM  = 2'd1,
    RGN_RAM  = 2'd2,
    RGN_PER  = 2'd3
  } region_e;
endpackage

// File: rtl/glue_decode.sv
module glue_decode
  import glue_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int ROM_OFF_W = 17
) (
  input  logic [ADDR_W-1:1]    addr_i,
  input  logic                 rw_i,
  input  logic                 super_i,
  input  logic                 two_banks_i,
  output region_e              region_o,
  output logic                 illegal_o,
  output logic                 rate_hit_o,
  output logic [ROM_OFF_W-1:0] rom_off_o
);
  logic [ADDR_W-1:0] baddr;
  logic ovl, rom, sys, low, high, per;

  assign baddr = {addr_i, 1'b0};

  always_comb begin
    ovl  = baddr < OVL_END;
    rom  = (baddr >= ROM_BASE) && (baddr < ROM_END);
    sys  = !ovl && (baddr < SYS_END);
    low  = !ovl && (baddr < LOW_END);
    high = (baddr >= LOW_END) && (baddr < HIGH_END);
    per  = baddr >= PER_BASE;

    illegal_o = ((ovl || rom) && !rw_i)
             || (sys && !super_i)
             || (high && !two_banks_i);

    if (ovl || rom)       region_o = RGN_ROM;
    else if (low || high) region_o = RGN_RAM;
    else if (per)         region_o = RGN_PER;
    else                  region_o = RGN_NONE;

    rate_hit_o = baddr == RATE_ADDR;
    // ROM base has zero in bits 17:0, so the offset is taken straight from the address
    rom_off_o  = (ovl || rom) ? addr_i[ROM_OFF_W:1] : '0;
  end
endmodule

// File: rtl/glue_berr_ctl.sv
module glue_berr_ctl #(
  parameter int TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_i,
  input  logic dtack_i,
  input  logic illegal_i,
  output logic berr_o
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             berr_q;
  logic             expire;

  assign expire = !dtack_i && (cnt_q == CNT_W'(TIMEOUT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      berr_q <= 1'b0;
    end else begin
      if (!as_i)                    cnt_q <= '0;
      else if (!dtack_i && !berr_q) cnt_q <= cnt_q + 1'b1;
      berr_q <= as_i && (berr_q || illegal_i || expire);
    end
  end

  assign berr_o = berr_q;
endmodule

// File: rtl/glue_irq_enc.sv
module glue_irq_enc #(
  parameter int IPL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mfp_i,
  input  logic             vsync_i,
  input  logic             hsync_i,
  output logic [IPL_W-1:0] ipl_o
);
  logic [IPL_W-1:0] lvl_d, lvl_q;

  always_comb begin
    if (hsync_i)      lvl_d = IPL_W'(3);
    else if (vsync_i) lvl_d = IPL_W'(2);
    else if (mfp_i)   lvl_d = IPL_W'(1);
    else              lvl_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_d;
  end

  assign ipl_o = lvl_q;
endmodule

// File: rtl/glue_rate_reg.sv
module glue_rate_reg #(
  parameter int DATA_W  = 8,
  parameter int RATE_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hz50_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic hz50_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hz50_q <= 1'b0;
    else if (wr_i) hz50_q <= data_i[RATE_BIT];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) rdata_o[RATE_BIT] = hz50_q;
  end

  assign hz50_o = hz50_q;
endmodule

// File: rtl/glue_bus_sup.sv
module glue_bus_sup
  import glue_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int ROM_OFF_W = 17,
  parameter int DATA_W    = 8,
  parameter int IPL_W     = 2,
  parameter int TIMEOUT   = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:1]    addr_i,
  input  logic                 as_i,
  input  logic                 rw_i,
  input  logic                 uds_i,
  input  logic                 lds_i,
  input  logic                 super_i,
  input  logic                 dtack_i,
  input  logic                 two_banks_i,
  input  logic                 irq_mfp_i,
  input  logic                 irq_vsync_i,
  input  logic                 irq_hsync_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic                 rom_sel_o,
  output logic                 ram_sel_o,
  output logic                 per_sel_o,
  output logic [ROM_OFF_W-1:0] rom_off_o,
  output logic                 dtack_o,
  output logic                 berr_o,
  output logic [IPL_W-1:0]     ipl_o,
  output logic                 hz50_o,
  output logic [DATA_W-1:0]    rdata_o
);
  region_e region;
  logic    illegal, rate_hit, cyc, ok, rate_acc;

  glue_decode #(.ADDR_W(ADDR_W), .ROM_OFF_W(ROM_OFF_W)) u_dec (
    .addr_i      (addr_i),
    .rw_i        (rw_i),
    .super_i     (super_i),
    .two_banks_i (two_banks_i),
    .region_o    (region),
    .illegal_o   (illegal),
    .rate_hit_o  (rate_hit),
    .rom_off_o   (rom_off_o)
  );

  assign cyc      = as_i && (uds_i || lds_i);
  assign ok       = cyc && !illegal;
  assign rom_sel_o = ok && (region == RGN_ROM);
  assign ram_sel_o = ok && (region == RGN_RAM);
  assign per_sel_o = ok && (region == RGN_PER);
  assign rate_acc = per_sel_o && rate_hit;
  // register cycles complete locally
  assign dtack_o  = dtack_i || rate_acc;

  glue_berr_ctl #(.TIMEOUT(TIMEOUT)) u_berr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .as_i      (as_i),
    .dtack_i   (dtack_o),
    .illegal_i (illegal),
    .berr_o    (berr_o)
  );

  glue_irq_enc #(.IPL_W(IPL_W)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mfp_i   (irq_mfp_i),
    .vsync_i (irq_vsync_i),
    .hsync_i (irq_hsync_i),
    .ipl_o   (ipl_o)
  );

  glue_rate_reg #(.DATA_W(DATA_W), .RATE_BIT(1)) u_rate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (rate_acc && !rw_i && uds_i),
    .rd_i    (rate_acc && rw_i && uds_i),
    .data_i  (data_i),
    .hz50_o  (hz50_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/glue_bus_sup_chk.sv
module glue_bus_sup_chk
  import glue_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int ROM_OFF_W = 17,
  parameter int IPL_W     = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:1]    addr_i,
  input logic                 as_i,
  input logic                 rw_i,
  input logic                 uds_i,
  input logic                 lds_i,
  input logic                 super_i,
  input logic                 two_banks_i,
  input logic                 irq_hsync_i,
  input logic                 rom_sel_o,
  input logic                 ram_sel_o,
  input logic                 per_sel_o,
  input logic                 berr_o,
  input logic [IPL_W-1:0]     ipl_o,
  input logic                 hz50_o
);
  logic [ADDR_W-1:0] ba;
  logic              strobe;
  assign ba     = {addr_i, 1'b0};
  assign strobe = as_i && (uds_i || lds_i);

  // R1
  a_r1_vector_from_rom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && rw_i && ba < OVL_END) |-> (rom_sel_o && !ram_sel_o));

  // R2
  a_r2_rom_write_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_i && !rw_i && (ba < OVL_END || (ba >= ROM_BASE && ba < ROM_END))) |=> berr_o);

  // R3
  a_r3_user_low_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_i && !super_i && ba >= OVL_END && ba < SYS_END) |=> berr_o);

  // R4
  a_r4_missing_bank_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_i && !two_banks_i && ba >= LOW_END && ba < HIGH_END) |=> berr_o);

  // R5
  a_r5_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_sel_o, ram_sel_o, per_sel_o}));

  // R7
  a_r7_berr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_i |=> !berr_o);

  a_r7_berr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_i && berr_o) |=> berr_o);

  // R8
  a_r8_hsync_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hsync_i |=> (ipl_o == IPL_W'(3)));

  // R9
  a_r9_rate_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(as_i && !rw_i && uds_i && ba == RATE_ADDR) |=> $stable(hz50_o));
endmodule

bind glue_bus_sup glue_bus_sup_chk #(
  .ADDR_W(ADDR_W), .ROM_OFF_W(ROM_OFF_W), .IPL_W(IPL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .as_i        (as_i),
  .rw_i        (rw_i),
  .uds_i       (uds_i),
  .lds_i       (lds_i),
  .super_i     (super_i),
  .two_banks_i (two_banks_i),
  .irq_hsync_i (irq_hsync_i),
  .rom_sel_o   (rom_sel_o),
  .ram_sel_o   (ram_sel_o),
  .per_sel_o   (per_sel_o),
  .berr_o      (berr_o),
  .ipl_o       (ipl_o),
  .hz50_o      (hz50_o)
);

// File: tb/glue_bus_sup_tb.sv
module glue_bus_sup_tb;
  localparam int TIMEOUT = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:1] addr_i = '0;
  logic        as_i = 0, rw_i = 1, uds_i = 0, lds_i = 0, super_i = 1;
  logic        dtack_i = 0, two_banks_i = 1;
  logic        irq_mfp_i = 0, irq_vsync_i = 0, irq_hsync_i = 0;
  logic [7:0]  data_i = '0;
  logic        rom_sel_o, ram_sel_o, per_sel_o, dtack_o, berr_o, hz50_o;
  logic [16:0] rom_off_o;
  logic [1:0]  ipl_o;
  logic [7:0]  rdata_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  glue_bus_sup #(.TIMEOUT(TIMEOUT)) u_dut (.*);

  typedef struct packed {
    logic [23:0] a;
    logic rw, sup, two;
    logic rom, ram, per, berr;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{24'h000004, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 overlay read
    '{24'h000006, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 overlay user read
    '{24'h000004, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 overlay write
    '{24'h FC1000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 rom read
    '{24'hFE0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 rom write
    '{24'h000400, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 user sys
    '{24'h000400, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 super sys
    '{24'h000800, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 boundary
    '{24'h250000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 high bank fitted
    '{24'h250000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 high bank absent
    '{24'h3FFFFE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 top of high bank
    '{24'h1FFFFE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 top of low bank
    '{24'hFF8800, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 peripheral
    '{24'h400000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}  // R5 unmapped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic start(input logic [23:0] a, input logic rw, input logic u);
    addr_i = a[23:1];
    rw_i   = rw;
    uds_i  = u;
    lds_i  = 1'b1;
    as_i   = 1'b1;
  endtask

  task automatic stop();
    as_i = 1'b0; uds_i = 1'b0; lds_i = 1'b0; dtack_i = 1'b0;
    step();
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    chk("R10 berr", berr_o, 0);
    chk("R10 ipl", ipl_o, 0);
    chk("R10 hz50", hz50_o, 0);

    for (int i = 0; i < NV; i++) begin
      super_i     = VECS[i].sup;
      two_banks_i = VECS[i].two;
      start(VECS[i].a, VECS[i].rw, 1'b1);
      #1;
      chk($sformatf("R5 rom_sel v%0d", i), rom_sel_o, VECS[i].rom);
      chk($sformatf("R5 ram_sel v%0d", i), ram_sel_o, VECS[i].ram);
      chk($sformatf("R5 per_sel v%0d", i), per_sel_o, VECS[i].per);
      step();
      chk($sformatf("R3 berr v%0d", i), berr_o, VECS[i].berr);
      stop();
      chk($sformatf("R7 berr cleared v%0d", i), berr_o, 0);
    end
    super_i = 1'b1; two_banks_i = 1'b1;

    // R1 / R2 offsets
    start(24'h000006, 1'b1, 1'b1); #1;
    chk("R1 rom_off", rom_off_o, 17'h3);
    stop();
    start(24'hFC1000, 1'b1, 1'b1); #1;
    chk("R2 rom_off", rom_off_o, 17'h800);
    stop();

    // R6 timeout then R7 hold
    start(24'h400000, 1'b1, 1'b1);
    repeat (TIMEOUT - 1) step();
    chk("R6 no berr before limit", berr_o, 0);
    step();
    chk("R6 berr at limit", berr_o, 1);
    repeat (3) step();
    chk("R7 berr held", berr_o, 1);
    stop();
    chk("R7 berr released", berr_o, 0);

    // R6 acknowledge on the deciding edge
    start(24'h400000, 1'b1, 1'b1);
    repeat (TIMEOUT - 1) step();
    dtack_i = 1'b1;
    step();
    chk("R6 dtack at limit wins", berr_o, 0);
    stop();

    // R3 protection beats timeout and holds
    super_i = 1'b0;
    start(24'h000100, 1'b1, 1'b1);
    step();
    chk("R3 immediate berr", berr_o, 1);
    repeat (TIMEOUT + 2) step();
    chk("R7 protection berr held", berr_o, 1);
    stop();
    super_i = 1'b1;

    // R8 priority
    irq_mfp_i = 1; step();
    chk("R8 mfp", ipl_o, 1);
    irq_vsync_i = 1; step();
    chk("R8 vsync over mfp", ipl_o, 2);
    irq_hsync_i = 1; step();
    chk("R8 hsync over all", ipl_o, 3);
    irq_mfp_i = 0; irq_vsync_i = 0; step();
    chk("R8 hsync alone", ipl_o, 3);
    irq_hsync_i = 0; step();
    chk("R8 none", ipl_o, 0);

    // R9 rate register
    data_i = 8'h02;
    start(24'hFF820A, 1'b0, 1'b1); #1;
    chk("R9 self ack", dtack_o, 1);
    step();
    chk("R9 set 50Hz", hz50_o, 1);
    chk("R9 no berr", berr_o, 0);
    stop();
    start(24'hFF820A, 1'b1, 1'b1); #1;
    chk("R9 readback", rdata_o, 8'h02);
    stop();
    data_i = 8'h00;
    start(24'hFF820A, 1'b0, 1'b0);
    step();
    chk("R9 lower lane ignored", hz50_o, 1);
    stop();
    start(24'hFF820A, 1'b0, 1'b1);
    step();
    chk("R9 back to 60Hz", hz50_o, 0);
    stop();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule